// File: doc/BRIEF.md
# Fixed-Period Hardware Watchdog Timer

This block is a watchdog that firmware can neither retune nor switch off. It counts ticks of a slow real-time-clock enable, nominally 32768 per second. Firmware has to restart the count by writing a one to a refresh bit before 49152 ticks (1.5 s) have gone by. Two other events restart the count: the wake signal being low, and the block being disabled. Only two inputs can stop the count. One is a debug-enable input and the other is a hardware strap. No register bit can stop it.

When the count runs out, the block does four things:
- it raises a one-cycle overflow pulse;
- it sets a sticky overflow flag;
- it drives a system reset output high for a fixed recovery interval of 4100 ticks;
- it gives a one-cycle launch pulse when that interval ends, which tells the processor to start fetching from address zero.

The overflow flag stays set through the reset that the block issues itself. Firmware can therefore tell a watchdog restart apart from a power-up. Firmware clears the flag after reading it, and the external reset pin also clears it.

Top module: `fixed_wdt`

## Requirements
- R1: With the count running, the TIMEOUT_TICKS-th tick after a restart is the overflow tick. ovf_pulse_o is high for exactly the one cycle after the edge that takes that tick.
- R2: A write to address 0 with data bit 0 set restarts the count at zero. A write to address 0 with bit 0 clear has no effect on the count.
- R3: While wake_i is low the count is held at zero, and ticks during that time do not count.
- R4: sys_rst_o goes high at the overflow edge and stays high until HOLD_TICKS further ticks have been taken. It falls at the same edge where launch_o rises. launch_o is high for a single cycle.
- R5: A refresh write during the hold phase is ignored. After the launch pulse the count starts from zero, so the next overflow needs a full TIMEOUT_TICKS ticks.
- R6: The overflow flag reads as bit 0 of address 1. Overflow sets it, and it stays set through the hold phase and the launch.
- R7: A write to address 1 with data bit 0 set clears the flag. If an overflow falls in the same cycle as that write, the flag stays set.
- R8: rst (the external reset pin, synchronous and active high) clears the flag, the count and the hold phase, and drives all three outputs low.
- R9: While dbg_en_i or strap_dis_i is high the count is held at zero and no overflow occurs.
- R10: The count advances only in cycles where tick_en_i is high. Cycles without a tick do not count.
- R11: Bit 1 of address 1 reads as one during the hold phase and as zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | External reset pin, synchronous, active high |
| tick_en_i | input | 1 | Time-base tick enable, one cycle per tick |
| wake_i | input | 1 | Wake signal; low restarts the count |
| dbg_en_i | input | 1 | Debug enable; high stops the watchdog |
| strap_dis_i | input | 1 | Hardware disable strap; high stops the watchdog |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address (0 control, 1 status) |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 1 | Read address |
| rd_data_o | output | 8 | Read data, combinational from rd_addr_i |
| ovf_pulse_o | output | 1 | One-cycle overflow pulse |
| sys_rst_o | output | 1 | System reset, high during the hold phase |
| launch_o | output | 1 | One-cycle launch pulse: the processor fetches from address 0 |

## Verification
The timeout is tested against several kinds of restart: a plain run from reset, a refresh write at tick 15, the wake signal held low across ticks, and a debug or strap hold lasting longer than the timeout. In each case, no overflow after TIMEOUT_TICKS-1 ticks followed by an overflow on the next tick shows that the restart reset the count exactly to zero, neither partly nor not at all. A run with two idle cycles between ticks separates tick counting from cycle counting. A refresh write placed inside the hold phase, followed by a timed second overflow, shows both that the write is ignored and that the count restarts after launch. Flag writes that coincide with an overflow, and a pin reset given after an overflow, separate the flag's set and clear priorities from the internal reset.

// File: rtl/fixed_wdt_pkg.sv
package fixed_wdt_pkg;

    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_HOLD = 1'b1
    } wdt_phase_e;

    localparam int unsigned DATA_W   = 8;
    localparam logic        ADR_CTRL = 1'b0;
    localparam logic        ADR_STAT = 1'b1;
    localparam int unsigned KICK_BIT = 0;
    localparam int unsigned FLAG_BIT = 0;
    localparam int unsigned HOLD_BIT = 1;

    typedef struct packed {
        logic kick;
        logic clr_flag;
    } wr_cmd_t;

    function automatic int unsigned span_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/wdt_span_ctr.sv
module wdt_span_ctr #(
    parameter int unsigned LIMIT = 49152
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic clear,
    output logic last
);
    import fixed_wdt_pkg::*;

    localparam int unsigned CW = span_width(LIMIT);
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign last = tick && !clear && (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

    AST_SPAN_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TOP); // R1

    AST_SPAN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0)); // R3

    AST_SPAN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clear) |=> $stable(cnt_q)); // R10

endmodule

// File: rtl/wdt_phase_seq.sv
module wdt_phase_seq #(
    parameter int unsigned HOLD_TICKS = 4100
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic expire,
    output logic hold_active,
    output logic launch
);
    import fixed_wdt_pkg::*;

    wdt_phase_e phase_q;
    logic       hold_done;
    logic       launch_q;

    wdt_span_ctr #(.LIMIT(HOLD_TICKS)) u_hold_ctr (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .clear (phase_q != PH_HOLD),
        .last  (hold_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_RUN;
            launch_q <= 1'b0;
        end else begin
            launch_q <= (phase_q == PH_HOLD) && hold_done;
            unique case (phase_q)
                PH_RUN:  if (expire)    phase_q <= PH_HOLD;
                PH_HOLD: if (hold_done) phase_q <= PH_RUN;
                default:                phase_q <= PH_RUN;
            endcase
        end
    end

    assign hold_active = (phase_q == PH_HOLD);
    assign launch      = launch_q;

    AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (!hold_active && expire) |=> hold_active); // R4

    AST_LAUNCH_EXIT: assert property (@(posedge clk) disable iff (rst)
        launch |-> (!hold_active && $past(hold_active))); // R4

    AST_LAUNCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        launch |=> !launch); // R4

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_en,
    input  logic                                 wr_addr,
    input  logic [fixed_wdt_pkg::DATA_W-1:0]     wr_data,
    input  logic                                 rd_addr,
    input  logic                                 set_flag,
    input  logic                                 hold_active,
    output fixed_wdt_pkg::wr_cmd_t               cmd,
    output logic [fixed_wdt_pkg::DATA_W-1:0]     rd_data
);
    import fixed_wdt_pkg::*;

    logic flag_q;

    always_comb begin
        cmd.kick     = wr_en && (wr_addr == ADR_CTRL) && wr_data[KICK_BIT];
        cmd.clr_flag = wr_en && (wr_addr == ADR_STAT) && wr_data[FLAG_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set_flag) begin
            flag_q <= 1'b1;
        end else if (cmd.clr_flag) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADR_STAT) begin
            rd_data[FLAG_BIT] = flag_q;
            rd_data[HOLD_BIT] = hold_active;
        end
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        set_flag |=> flag_q); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !cmd.clr_flag) |=> flag_q); // R6

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr_flag && !set_flag) |=> !flag_q); // R7

endmodule

// File: rtl/fixed_wdt.sv
module fixed_wdt #(
    parameter int unsigned TIMEOUT_TICKS = 49152,
    parameter int unsigned HOLD_TICKS    = 4100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en_i,
    input  logic       wake_i,
    input  logic       dbg_en_i,
    input  logic       strap_dis_i,
    input  logic       wr_en_i,
    input  logic       wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic       rd_addr_i,
    output logic [7:0] rd_data_o,
    output logic       ovf_pulse_o,
    output logic       sys_rst_o,
    output logic       launch_o
);
    import fixed_wdt_pkg::*;

    wr_cmd_t cmd;
    logic    hold_active;
    logic    restart;
    logic    expire;
    logic    ovf_q;

    assign restart = cmd.kick || !wake_i || dbg_en_i || strap_dis_i || hold_active;

    wdt_span_ctr #(.LIMIT(TIMEOUT_TICKS)) u_timeout_ctr (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_en_i),
        .clear (restart),
        .last  (expire)
    );

    wdt_phase_seq #(.HOLD_TICKS(HOLD_TICKS)) u_phase (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick_en_i),
        .expire      (expire),
        .hold_active (hold_active),
        .launch      (launch_o)
    );

    wdt_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en_i),
        .wr_addr     (wr_addr_i),
        .wr_data     (wr_data_i),
        .rd_addr     (rd_addr_i),
        .set_flag    (expire),
        .hold_active (hold_active),
        .cmd         (cmd),
        .rd_data     (rd_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) ovf_q <= 1'b0;
        else     ovf_q <= expire;
    end

    assign ovf_pulse_o = ovf_q;
    assign sys_rst_o   = hold_active;

    AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse_o |=> !ovf_pulse_o); // R1

    AST_OVF_WITH_RST: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse_o |-> sys_rst_o); // R4

    AST_NO_OVF_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (dbg_en_i || strap_dis_i) |-> !expire); // R9

    AST_NO_OVF_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        !wake_i |-> !expire); // R3

endmodule

// File: tb/fixed_wdt_test.sv
module fixed_wdt_test;
    localparam int CLK_PERIOD = 10;
    localparam int TO = 20;
    localparam int HO = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en_i = 1'b0;
    logic       wake_i = 1'b1;
    logic       dbg_en_i = 1'b0;
    logic       strap_dis_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       wr_addr_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic       rd_addr_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       ovf_pulse_o, sys_rst_o, launch_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fixed_wdt #(.TIMEOUT_TICKS(TO), .HOLD_TICKS(HO)) uut (
        .clk(clk), .rst(rst), .tick_en_i(tick_en_i), .wake_i(wake_i),
        .dbg_en_i(dbg_en_i), .strap_dis_i(strap_dis_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .ovf_pulse_o(ovf_pulse_o), .sys_rst_o(sys_rst_o),
        .launch_o(launch_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en_i = 1'b1;
            @(negedge clk);
        end
        tick_en_i = 1'b0;
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    function automatic int stat_bit(input int b);
        return int'(rd_data_o[b]);
    endfunction

    task automatic read_stat(output int flag, output int hold);
        rd_addr_i = 1'b1;
        #1;
        flag = stat_bit(0);
        hold = stat_bit(1);
        rd_addr_i = 1'b0;
    endtask

    task automatic t_reset();
        int f, h;
        do_reset();
        read_stat(f, h);
        check("R8 reset sys_rst", sys_rst_o, 0);
        check("R8 reset launch", launch_o, 0);
        check("R8 reset ovf", ovf_pulse_o, 0);
        check("R8 reset flag", f, 0);
    endtask

    task automatic t_timeout();
        int f, h;
        do_reset();
        ticks(TO - 1);
        check("R1 no ovf before limit", ovf_pulse_o, 0);
        check("R1 no sys_rst before limit", sys_rst_o, 0);
        ticks(1);
        check("R1 ovf on limit tick", ovf_pulse_o, 1);
        check("R4 sys_rst at overflow", sys_rst_o, 1);
        read_stat(f, h);
        check("R6 flag set", f, 1);
        check("R11 hold bit set", h, 1);
        @(negedge clk);
        check("R1 ovf one cycle", ovf_pulse_o, 0);
        ticks(3);
        reg_write(1'b0, 8'h01);
        ticks(HO - 4);
        check("R4 sys_rst held", sys_rst_o, 1);
        check("R4 no early launch", launch_o, 0);
        ticks(1);
        check("R4 sys_rst released", sys_rst_o, 0);
        check("R5 launch after full hold despite refresh", launch_o, 1);
        read_stat(f, h);
        check("R6 flag survives hold", f, 1);
        check("R11 hold bit clear", h, 0);
        @(negedge clk);
        check("R4 launch one cycle", launch_o, 0);
        ticks(TO - 1);
        check("R5 count restarted after launch", ovf_pulse_o | sys_rst_o, 0);
        ticks(1);
        check("R5 second overflow", ovf_pulse_o, 1);
    endtask

    task automatic t_refresh();
        do_reset();
        ticks(15);
        reg_write(1'b0, 8'h00);
        ticks(TO - 15);
        check("R2 bit0 clear has no effect", ovf_pulse_o, 1);
        do_reset();
        ticks(15);
        reg_write(1'b0, 8'h01);
        ticks(TO - 1);
        check("R2 refresh restarts", ovf_pulse_o | sys_rst_o, 0);
        ticks(1);
        check("R2 overflow after refresh", ovf_pulse_o, 1);
    endtask

    task automatic t_wake();
        do_reset();
        ticks(15);
        wake_i = 1'b0;
        ticks(3);
        wake_i = 1'b1;
        ticks(TO - 1);
        check("R3 wake low restarts", ovf_pulse_o | sys_rst_o, 0);
        ticks(1);
        check("R3 overflow after wake", ovf_pulse_o, 1);
    endtask

    task automatic t_disable(input bit use_strap);
        int f, h;
        do_reset();
        if (use_strap) strap_dis_i = 1'b1; else dbg_en_i = 1'b1;
        ticks(2 * TO);
        read_stat(f, h);
        check(use_strap ? "R9 strap stops" : "R9 debug stops", sys_rst_o + f, 0);
        strap_dis_i = 1'b0; dbg_en_i = 1'b0;
        ticks(TO - 1);
        check("R9 count held at zero", ovf_pulse_o | sys_rst_o, 0);
        ticks(1);
        check("R9 overflow after release", ovf_pulse_o, 1);
    endtask

    task automatic t_gaps();
        do_reset();
        for (int i = 0; i < TO - 1; i++) begin
            tick_en_i = 1'b1; @(negedge clk);
            tick_en_i = 1'b0; @(negedge clk); @(negedge clk);
        end
        check("R10 idle cycles not counted", ovf_pulse_o | sys_rst_o, 0);
        ticks(1);
        check("R10 overflow on tick count", ovf_pulse_o, 1);
    endtask

    task automatic t_flag_clear();
        int f, h;
        do_reset();
        ticks(TO - 1);
        tick_en_i = 1'b1;
        reg_write(1'b1, 8'h01);
        tick_en_i = 1'b0;
        read_stat(f, h);
        check("R7 set wins over clear", f, 1);
        reg_write(1'b1, 8'h00);
        read_stat(f, h);
        check("R7 write bit0 clear keeps flag", f, 1);
        reg_write(1'b1, 8'h01);
        read_stat(f, h);
        check("R7 clear flag", f, 0);
    endtask

    task automatic t_pin_reset();
        int f, h;
        do_reset();
        ticks(TO + 2);
        do_reset();
        read_stat(f, h);
        check("R8 pin clears flag", f, 0);
        check("R8 pin ends hold", sys_rst_o, 0);
        ticks(TO - 1);
        check("R8 pin clears count", ovf_pulse_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_timeout();
        t_refresh();
        t_wake();
        t_disable(1'b0);
        t_disable(1'b1);
        t_gaps();
        t_flag_clear();
        t_pin_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule